// File: doc/BRIEF.md
# Multi-channel crypto task scheduler

This block is the command front end of a group of four cipher cores. A host sends commands over a single valid/ready control port. The commands open and close channels, request an encryption or decryption job for one packet, and report that a data transfer has finished. The block keeps a sixteen-entry channel table. Each entry holds a valid bit, a key identifier, an algorithm code and a tag size. For every packet request the block picks idle cores, lowest index first, and starts them with the channel's parameters. It steers the host data port through a crossbar and answers each command with a status code.

A packet that uses counter mode with CBC-MAC (algorithm code 2) takes two cores at once: a primary core and a partner core. Every other algorithm takes one core. Several packets, from one channel or from different channels, can run on different cores at the same time. The crossbar input leg points at the core that is currently being loaded. The output leg points at a finished core that is waiting to be drained. When no cores are free, a job request is held and retried every cycle until a core is released. A decryption whose core reported an authentication failure is answered with a distinct status when that core is released.

Top module: `crypto_task_sched`

## Requirements
- R1: After reset, `rsp_valid`, `job_start`, `xb_in_en` and `xb_out_en` are 0, `cmd_ready` is 1, and every channel is closed.
- R2: Command codes are 1 open, 2 close, 3 encrypt, 4 decrypt and 5 transfer-done. Status codes are 0 OK, 1 no channel, 2 busy, 3 bad command and 4 auth fail. Open on a closed channel stores its key, algorithm and tag and answers 0. Open on an open channel answers 2 and changes nothing.
- R3: Close on an open channel answers 0. Close, encrypt or decrypt on a closed channel answers 1. Each of these answers appears one cycle after acceptance.
- R4: Encrypt or decrypt on an open channel, with enough idle cores, answers status 0 two cycles after acceptance. In the same cycle `job_start` pulses for the lowest-index idle core, with the channel's key, algorithm and tag, the request size, and `job_dec` set for decrypt. `rsp_core` names the core.
- R5: A job on a channel with algorithm 2 starts the two lowest-index idle cores together. `rsp_core` is the lower core and is the primary; `rsp_mate` is the higher core. Any other algorithm starts one core, and `rsp_mate` equals `rsp_core`.
- R6: A job that finds too few idle cores produces no response and keeps `cmd_ready` low for further job commands, while other commands are still accepted. The job starts in the cycle after the response to the command that frees enough cores.
- R7: A job start points the crossbar input leg (`xb_in_en`, `xb_in_sel`) at its primary core. The leg is cleared by transfer-done on that core while it runs, or when that core is released.
- R8: `core_done` on a running primary core marks it and its partner finished. `xb_out_en`/`xb_out_sel` then select the lowest-index finished primary core. `core_done` on an idle, already finished or partner core is ignored.
- R9: Transfer-done on a finished primary core releases it and its partner. It answers 4 if the job was a decrypt and the core raised `core_auth_fail` with its done pulse; otherwise it answers 0.
- R10: Transfer-done on a running primary core answers 0. Transfer-done on an idle or partner core, and any undefined command code, answers 3.
- R11: Two jobs from the same channel run at the same time on different cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted on this edge when valid |
| cmd_op | input | 3 | Command code |
| cmd_chan | input | 4 | Channel number |
| cmd_key | input | 8 | Key identifier (open) |
| cmd_alg | input | 2 | Algorithm code (open) |
| cmd_tag | input | 4 | Tag size (open) |
| cmd_size | input | 16 | Packet size (encrypt/decrypt) |
| cmd_core | input | 2 | Core number (transfer-done) |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 3 | Status code |
| rsp_core | output | 2 | Primary core of a started job |
| rsp_mate | output | 2 | Partner core of a started job |
| job_start | output | 4 | Per-core start pulse |
| job_key | output | 8 | Key identifier for started cores |
| job_alg | output | 2 | Algorithm for started cores |
| job_tag | output | 4 | Tag size for started cores |
| job_size | output | 16 | Packet size for started cores |
| job_dec | output | 1 | 1 for decrypt |
| core_done | input | 4 | Per-core finish pulse |
| core_auth_fail | input | 4 | Per-core authentication failure, valid with done |
| xb_in_en | output | 1 | Host data routed into a core input |
| xb_in_sel | output | 2 | Core whose input is routed |
| xb_out_en | output | 1 | A core output is routed to the host |
| xb_out_sel | output | 2 | Core whose output is routed |

## Verification
Directed sequences compare single-core jobs with paired algorithm-2 jobs. This shows whether the allocator counts cores per algorithm and keeps the lowest-first order when cores are freed out of order. An all-cores-busy case with a held request tells retry timing apart from dropped or early starts. It also checks that release, rather than the done pulse, is what frees a core. Done pulses aimed at idle and partner cores, together with auth failures on encrypt and on decrypt, separate the routing and status paths. A seeded random mix of open, close, job, done and transfer commands is checked against a reference model of the table and the cores.

// File: rtl/crypto_task_sched.sv
module crypto_task_sched #(
  parameter int N_CH   = 16,
  parameter int N_CORE = 4,
  parameter int KEY_W  = 8,
  parameter int SIZE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(N_CH)-1:0]   cmd_chan,
  input  logic [KEY_W-1:0]          cmd_key,
  input  logic [1:0]                cmd_alg,
  input  logic [3:0]                cmd_tag,
  input  logic [SIZE_W-1:0]         cmd_size,
  input  logic [$clog2(N_CORE)-1:0] cmd_core,
  output logic                      rsp_valid,
  output logic [2:0]                rsp_status,
  output logic [$clog2(N_CORE)-1:0] rsp_core,
  output logic [$clog2(N_CORE)-1:0] rsp_mate,
  output logic [N_CORE-1:0]         job_start,
  output logic [KEY_W-1:0]          job_key,
  output logic [1:0]                job_alg,
  output logic [3:0]                job_tag,
  output logic [SIZE_W-1:0]         job_size,
  output logic                      job_dec,
  input  logic [N_CORE-1:0]         core_done,
  input  logic [N_CORE-1:0]         core_auth_fail,
  output logic                      xb_in_en,
  output logic [$clog2(N_CORE)-1:0] xb_in_sel,
  output logic                      xb_out_en,
  output logic [$clog2(N_CORE)-1:0] xb_out_sel
);
  localparam int CW = $clog2(N_CORE);
  localparam [2:0] OP_OPEN = 3'd1, OP_CLOSE = 3'd2, OP_ENC = 3'd3, OP_DEC = 3'd4, OP_XFER = 3'd5;
  localparam [2:0] S_OK = 3'd0, S_NOCH = 3'd1, S_BUSY = 3'd2, S_BAD = 3'd3, S_AUTH = 3'd4;
  localparam [1:0] ALG_PAIR = 2'd2;
  localparam [1:0] C_IDLE = 2'd0, C_RUN = 2'd1, C_DONE = 2'd2;

  logic [N_CH-1:0]   ch_v;
  logic [KEY_W-1:0]  ch_key [N_CH];
  logic [1:0]        ch_alg [N_CH];
  logic [3:0]        ch_tag [N_CH];

  logic [1:0]        cst    [N_CORE];
  logic [CW-1:0]     c_mate [N_CORE];
  logic [N_CORE-1:0] c_prim, c_dec, c_auth, busy;

  logic              pend_v, pend_dec;
  logic [KEY_W-1:0]  pend_key;
  logic [1:0]        pend_alg;
  logic [3:0]        pend_tag;
  logic [SIZE_W-1:0] pend_size;

  logic          f0_ok, f1_ok, out_ok;
  logic [CW-1:0] f0, f1, out_c;

  always_comb begin
    f0_ok = 1'b0; f1_ok = 1'b0; f0 = '0; f1 = '0;
    out_ok = 1'b0; out_c = '0;
    for (int i = 0; i < N_CORE; i++) begin
      busy[i] = cst[i] != C_IDLE;
      if (cst[i] == C_IDLE) begin
        if (!f0_ok) begin f0_ok = 1'b1; f0 = CW'(i); end
        else if (!f1_ok) begin f1_ok = 1'b1; f1 = CW'(i); end
      end
      if (!out_ok && cst[i] == C_DONE && c_prim[i]) begin
        out_ok = 1'b1; out_c = CW'(i);
      end
    end
  end

  wire need2  = pend_alg == ALG_PAIR;
  wire grant  = pend_v && f0_ok && (!need2 || f1_ok);
  wire job_op = cmd_op == OP_ENC || cmd_op == OP_DEC;
  wire acc    = cmd_valid && cmd_ready;

  assign cmd_ready  = !(grant || (pend_v && job_op));
  assign xb_out_en  = out_ok;
  assign xb_out_sel = out_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_v <= '0;
      pend_v <= 1'b0; pend_dec <= 1'b0; pend_key <= '0; pend_alg <= '0; pend_tag <= '0; pend_size <= '0;
      rsp_valid <= 1'b0; rsp_status <= S_OK; rsp_core <= '0; rsp_mate <= '0;
      job_start <= '0; job_key <= '0; job_alg <= '0; job_tag <= '0; job_size <= '0; job_dec <= 1'b0;
      xb_in_en <= 1'b0; xb_in_sel <= '0;
      c_prim <= '0; c_dec <= '0; c_auth <= '0;
      for (int i = 0; i < N_CORE; i++) begin
        cst[i] <= C_IDLE; c_mate[i] <= CW'(i);
      end
    end else begin
      rsp_valid <= 1'b0;
      job_start <= '0;

      for (int i = 0; i < N_CORE; i++)
        if (core_done[i] && cst[i] == C_RUN && c_prim[i]) begin
          cst[i] <= C_DONE;
          cst[c_mate[i]] <= C_DONE;
          c_auth[i] <= core_auth_fail[i] & c_dec[i];
        end

      if (acc) begin
        rsp_valid <= 1'b1;
        rsp_core  <= cmd_core;
        rsp_mate  <= cmd_core;
        case (cmd_op)
          OP_OPEN:
            if (ch_v[cmd_chan]) rsp_status <= S_BUSY;
            else begin
              ch_v[cmd_chan]   <= 1'b1;
              ch_key[cmd_chan] <= cmd_key;
              ch_alg[cmd_chan] <= cmd_alg;
              ch_tag[cmd_chan] <= cmd_tag;
              rsp_status <= S_OK;
            end
          OP_CLOSE:
            if (ch_v[cmd_chan]) begin
              ch_v[cmd_chan] <= 1'b0;
              rsp_status <= S_OK;
            end else rsp_status <= S_NOCH;
          OP_ENC, OP_DEC:
            if (!ch_v[cmd_chan]) rsp_status <= S_NOCH;
            else begin
              rsp_valid <= 1'b0;
              pend_v    <= 1'b1;
              pend_dec  <= cmd_op == OP_DEC;
              pend_key  <= ch_key[cmd_chan];
              pend_alg  <= ch_alg[cmd_chan];
              pend_tag  <= ch_tag[cmd_chan];
              pend_size <= cmd_size;
            end
          OP_XFER:
            if (c_prim[cmd_core] && cst[cmd_core] == C_RUN) begin
              rsp_status <= S_OK;
              if (xb_in_en && xb_in_sel == cmd_core) xb_in_en <= 1'b0;
            end else if (c_prim[cmd_core] && cst[cmd_core] == C_DONE) begin
              cst[cmd_core] <= C_IDLE;
              cst[c_mate[cmd_core]] <= C_IDLE;
              rsp_status <= c_auth[cmd_core] ? S_AUTH : S_OK;
              if (xb_in_en && xb_in_sel == cmd_core) xb_in_en <= 1'b0;
            end else rsp_status <= S_BAD;
          default: rsp_status <= S_BAD;
        endcase
      end

      if (grant) begin
        pend_v     <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_status <= S_OK;
        rsp_core   <= f0;
        rsp_mate   <= need2 ? f1 : f0;
        cst[f0]    <= C_RUN;
        c_prim[f0] <= 1'b1;
        c_mate[f0] <= need2 ? f1 : f0;
        c_dec[f0]  <= pend_dec;
        c_auth[f0] <= 1'b0;
        if (need2) begin
          cst[f1]    <= C_RUN;
          c_prim[f1] <= 1'b0;
          c_mate[f1] <= f0;
        end
        job_start <= (N_CORE'(1) << f0) | (need2 ? (N_CORE'(1) << f1) : '0);
        job_key   <= pend_key;
        job_alg   <= pend_alg;
        job_tag   <= pend_tag;
        job_size  <= pend_size;
        job_dec   <= pend_dec;
        xb_in_en  <= 1'b1;
        xb_in_sel <= f0;
      end
    end
  end

  a_r4_start_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (|job_start) |-> (rsp_valid && rsp_status == S_OK));

  a_r4_fresh_core: assert property (@(posedge clk) disable iff (!rst_n)
    (|job_start) |-> ((job_start & $past(busy)) == '0));

  a_r5_core_count: assert property (@(posedge clk) disable iff (!rst_n)
    (|job_start) |-> ($countones(job_start) == ((job_alg == ALG_PAIR) ? 2 : 1)));

  a_r7_in_route_live: assert property (@(posedge clk) disable iff (!rst_n)
    xb_in_en |-> busy[xb_in_sel]);

  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !grant) |=> pend_v);

  a_r9_auth_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == S_AUTH) |-> $past(cmd_valid && cmd_op == OP_XFER));
endmodule

// File: tb/crypto_task_sched_tb.sv
module crypto_task_sched_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [3:0]  cmd_chan = '0;
  logic [7:0]  cmd_key = '0;
  logic [1:0]  cmd_alg = '0;
  logic [3:0]  cmd_tag = '0;
  logic [15:0] cmd_size = '0;
  logic [1:0]  cmd_core = '0;
  logic [3:0]  core_done = '0, core_auth_fail = '0;
  logic        cmd_ready, rsp_valid, job_dec, xb_in_en, xb_out_en;
  logic [2:0]  rsp_status;
  logic [1:0]  rsp_core, rsp_mate, job_alg, xb_in_sel, xb_out_sel;
  logic [3:0]  job_start, job_tag;
  logic [7:0]  job_key;
  logic [15:0] job_size;

  crypto_task_sched u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_key(cmd_key), .cmd_alg(cmd_alg),
    .cmd_tag(cmd_tag), .cmd_size(cmd_size), .cmd_core(cmd_core),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_core(rsp_core), .rsp_mate(rsp_mate),
    .job_start(job_start), .job_key(job_key), .job_alg(job_alg), .job_tag(job_tag),
    .job_size(job_size), .job_dec(job_dec), .core_done(core_done), .core_auth_fail(core_auth_fail),
    .xb_in_en(xb_in_en), .xb_in_sel(xb_in_sel), .xb_out_en(xb_out_en), .xb_out_sel(xb_out_sel));

  int checks = 0, fails = 0;

  bit         m_cv [16];
  logic [7:0] m_key [16];
  logic [1:0] m_alg [16];
  logic [3:0] m_tag [16];
  int         m_st [4];
  bit         m_prim [4], m_dec [4], m_auth [4];
  int         m_mate [4];
  bit         m_in_en;
  int         m_in_sel;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int n_free();
    int n = 0;
    for (int i = 0; i < 4; i++) if (m_st[i] == 0) n++;
    return n;
  endfunction

  task automatic check_xbar(input string req);
    int oc = -1;
    for (int i = 3; i >= 0; i--) if (m_st[i] == 2 && m_prim[i]) oc = i;
    chk(req, "xb_out_en", xb_out_en, oc >= 0);
    if (oc >= 0) chk(req, "xb_out_sel", xb_out_sel, oc);
    chk(req, "xb_in_en", xb_in_en, m_in_en);
    if (m_in_en) chk(req, "xb_in_sel", xb_in_sel, m_in_sel);
  endtask

  task automatic send(input logic [2:0] op, input int ch, input logic [7:0] key, input logic [1:0] alg,
                      input logic [3:0] tg, input logic [15:0] sz, input int core);
    @(negedge clk);
    cmd_op = op; cmd_chan = 4'(ch); cmd_key = key; cmd_alg = alg; cmd_tag = tg;
    cmd_size = sz; cmd_core = 2'(core); cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_grant(input string req, input int ch, input bit dec, input logic [15:0] sz);
    int f0 = -1, f1 = -1;
    bit two = m_alg[ch] == 2'd2;
    logic [3:0] mask;
    for (int i = 0; i < 4; i++)
      if (m_st[i] == 0) begin
        if (f0 < 0) f0 = i; else if (f1 < 0) f1 = i;
      end
    mask = 4'(1 << f0) | (two ? 4'(1 << f1) : 4'd0);
    chk(req, "grant rsp_valid", rsp_valid, 1);
    chk(req, "grant status", rsp_status, 0);
    chk(req, "rsp_core", rsp_core, f0);
    chk(req, "rsp_mate", rsp_mate, two ? f1 : f0);
    chk(req, "job_start", job_start, mask);
    chk(req, "job_key", job_key, m_key[ch]);
    chk(req, "job_alg", job_alg, m_alg[ch]);
    chk(req, "job_tag", job_tag, m_tag[ch]);
    chk(req, "job_size", job_size, sz);
    chk(req, "job_dec", job_dec, dec);
    m_st[f0] = 1; m_prim[f0] = 1; m_dec[f0] = dec; m_auth[f0] = 0;
    m_mate[f0] = two ? f1 : f0;
    if (two) begin m_st[f1] = 1; m_prim[f1] = 0; m_mate[f1] = f0; end
    m_in_en = 1; m_in_sel = f0;
  endtask

  task automatic run_cmd(input string req, input logic [2:0] op, input int ch, input logic [7:0] key,
                         input logic [1:0] alg, input logic [3:0] tg, input logic [15:0] sz, input int core);
    logic [2:0] es = 3'd3;
    bit job = (op == 3'd3 || op == 3'd4) && m_cv[ch];
    case (op)
      3'd1: es = m_cv[ch] ? 3'd2 : 3'd0;
      3'd2, 3'd3, 3'd4: es = m_cv[ch] ? 3'd0 : 3'd1;
      3'd5: if (m_st[core] == 1 && m_prim[core]) es = 3'd0;
            else if (m_st[core] == 2 && m_prim[core]) es = m_auth[core] ? 3'd4 : 3'd0;
            else es = 3'd3;
      default: es = 3'd3;
    endcase
    send(op, ch, key, alg, tg, sz, core);
    if (job) begin
      chk(req, "no rsp at accept", rsp_valid, 0);
      @(negedge clk);
      expect_grant(req, ch, op == 3'd4, sz);
    end else begin
      chk(req, "rsp_valid", rsp_valid, 1);
      chk(req, "rsp_status", rsp_status, es);
      chk(req, "no job_start", job_start, 0);
      if (op == 3'd1 && !m_cv[ch]) begin m_cv[ch] = 1; m_key[ch] = key; m_alg[ch] = alg; m_tag[ch] = tg; end
      if (op == 3'd2) m_cv[ch] = 0;
      if (op == 3'd5 && m_prim[core]) begin
        if (m_st[core] == 1 && m_in_en && m_in_sel == core) m_in_en = 0;
        else if (m_st[core] == 2) begin
          m_st[core] = 0; m_st[m_mate[core]] = 0;
          if (m_in_en && m_in_sel == core) m_in_en = 0;
        end
      end
    end
    check_xbar(req);
  endtask

  task automatic pulse_done(input string req, input int c, input bit au);
    @(negedge clk);
    core_done = 4'(1 << c);
    core_auth_fail = au ? 4'(1 << c) : 4'd0;
    @(negedge clk);
    core_done = '0; core_auth_fail = '0;
    if (m_st[c] == 1 && m_prim[c]) begin
      m_st[c] = 2; m_st[m_mate[c]] = 2; m_auth[c] = au && m_dec[c];
    end
    check_xbar(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_cv[i] = 0;
    for (int i = 0; i < 4; i++) begin m_st[i] = 0; m_prim[i] = 0; m_dec[i] = 0; m_auth[i] = 0; m_mate[i] = i; end
    m_in_en = 0; m_in_sel = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "job_start", job_start, 0);
    chk("R1", "xb_in_en", xb_in_en, 0);
    chk("R1", "xb_out_en", xb_out_en, 0);
    chk("R1", "cmd_ready", cmd_ready, 1);

    run_cmd("R3", 3'd3, 3, 8'h00, 2'd0, 4'd0, 16'd10, 0);
    run_cmd("R3", 3'd2, 3, 8'h00, 2'd0, 4'd0, 16'd0, 0);
    run_cmd("R2", 3'd1, 3, 8'h5A, 2'd1, 4'd8, 16'd0, 0);
    run_cmd("R2", 3'd1, 3, 8'hC3, 2'd0, 4'd4, 16'd0, 0);
    run_cmd("R4", 3'd3, 3, 8'h00, 2'd0, 4'd0, 16'd64, 0);
    run_cmd("R11", 3'd3, 3, 8'h00, 2'd0, 4'd0, 16'd80, 0);
    run_cmd("R2", 3'd1, 7, 8'h21, 2'd2, 4'd12, 16'd0, 0);
    run_cmd("R5", 3'd4, 7, 8'h00, 2'd0, 4'd0, 16'd96, 0);

    send(3'd3, 3, 8'h00, 2'd0, 4'd0, 16'd200, 0);
    chk("R6", "no rsp when full", rsp_valid, 0);
    @(negedge clk);
    chk("R6", "still pending", rsp_valid, 0);
    chk("R6", "no start when full", job_start, 0);
    cmd_op = 3'd4; cmd_valid = 1'b1;
    #1 chk("R6", "job cmd blocked", cmd_ready, 0);
    cmd_op = 3'd1;
    #1 chk("R6", "other cmd open", cmd_ready, 1);
    cmd_valid = 1'b0;

    run_cmd("R7", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, 2);
    pulse_done("R8", 3, 1'b0);
    pulse_done("R8", 2, 1'b1);
    pulse_done("R8", 2, 1'b0);
    run_cmd("R10", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, 3);
    run_cmd("R9", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, 2);
    @(negedge clk);
    expect_grant("R6", 3, 1'b0, 16'd200);
    check_xbar("R7");

    pulse_done("R8", 0, 1'b1);
    run_cmd("R9", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, 0);
    run_cmd("R10", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, 0);
    run_cmd("R10", 3'd7, 0, 8'h00, 2'd0, 4'd0, 16'd0, 0);
    run_cmd("R3", 3'd2, 3, 8'h00, 2'd0, 4'd0, 16'd0, 0);
    run_cmd("R3", 3'd4, 3, 8'h00, 2'd0, 4'd0, 16'd5, 0);

    for (int it = 0; it < 600; it++) begin
      int sel = int'($urandom % 10);
      int ch = int'($urandom % 16);
      int c = int'($urandom % 4);
      logic [2:0] jop = ($urandom % 2) ? 3'd3 : 3'd4;
      int need = (m_cv[ch] && m_alg[ch] == 2'd2) ? 2 : 1;
      if (sel < 2)
        run_cmd("R2", 3'd1, ch, 8'($urandom), 2'($urandom), 4'($urandom), 16'd0, 0);
      else if (sel == 2)
        run_cmd("R3", 3'd2, ch, 8'h00, 2'd0, 4'd0, 16'd0, 0);
      else if (sel < 5 && (!m_cv[ch] || n_free() >= need))
        run_cmd("R4", jop, ch, 8'h00, 2'd0, 4'd0, 16'($urandom), 0);
      else if (sel < 8)
        pulse_done("R8", c, 1'($urandom));
      else
        run_cmd("R9", 3'd5, 0, 8'h00, 2'd0, 4'd0, 16'd0, c);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule